// File: doc/BRIEF.md
# Loopback and Bypass Path Controller

This block holds the loopback and bypass mode bits of a symbol-oriented physical-layer transceiver and steers its 10-bit data paths from them. It picks what the receive output carries: the normal receive path (returned from the external framer and elasticity buffer), the transmit input looped straight across, or a constant Idle fill. It also picks what feeds the external framer (line symbols, or transmit symbols during a local loop or self-test). Finally, it decides whether the transmit output carries the host's transmit data or received symbols sent back toward the line.

Two kinds of gating come from a 2-bit connection-management state input. The two local-loop bits accept writes only in the OFF or MAINT states. The bypass and remote-loop bits can be written in any state, but they steer their multiplexers only in MAINT or while a configuration-override input is high. A small self-test sequencer is started and aborted through a run bit in the same register. Framing, buffering, scrambling and line coding live outside the block and connect through pass-through ports.

Top module: `lbk_path_ctrl`

## Requirements
- R1: After reset every mode bit is clear, so `rx_out` equals `eb_rx`, `tx_out` equals `tx_in`, `framer_in` equals `line_rx`, and `bist_busy` and `bist_done` are low.
- R2: When the bypass bit (bit 0) is in effect and `scrub_req` is high, `rx_out` is the Idle fill 10'h3FF (two all-ones 5-bit symbols).
- R3: When the bypass bit is in effect and `scrub_req` is low, `rx_out` equals `tx_in`.
- R4: Bypass (bit 0) and remote loop (bit 1) are stored on any write, but they are in effect only while `mgmt_state` is MAINT (1) or `cfg_override` is high. OFF is 0; 2 and 3 are the other states.
- R5: Writes to the early local-loop bit (bit 2) and the late local-loop bit (bit 3) are applied only while `mgmt_state` is OFF (0) or MAINT (1). In states 2 and 3 those two bits keep their old values.
- R6: With the early local-loop bit set, `framer_in` equals `tx_in`.
- R7: With the late local-loop bit set and bypass not in effect, `rx_out` equals `tx_in`. Otherwise, with bypass not in effect, `rx_out` equals `eb_rx`.
- R8: With remote loop in effect, `tx_out` equals `eb_rx`, but only when neither local-loop bit is set and `cipher_lpbk` is low. In every other case `tx_out` equals `tx_in`.
- R9: Writing the run bit (bit 4) as 1 raises `bist_busy` from the next clock edge for exactly 64 cycles. `bist_done` is then high for one cycle.
- R10: Clearing the run bit while the self-test is busy drops `bist_busy` at the second clock edge after the write, and `bist_done` does not pulse.
- R11: After completion, a run bit that stays high does not restart the self-test. Writing it 0 and then 1 starts a new run.
- R12: While `bist_busy` is high, `framer_in` equals `tx_in`.
- R13: The mode register sits at address 0. A write to any other address changes no mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 5 | Write data: bit0 bypass, bit1 remote loop, bit2 early loop, bit3 late loop, bit4 self-test run |
| mgmt_state | input | 2 | Connection-management state: 0 OFF, 1 MAINT, 2/3 others |
| cfg_override | input | 1 | Lets bypass and remote loop act outside MAINT |
| scrub_req | input | 1 | Scrub request; selects Idle fill under bypass |
| cipher_lpbk | input | 1 | Cipher loopback active elsewhere; blocks remote loop |
| line_rx | input | 10 | Symbols arriving from the line |
| tx_in | input | 10 | Transmit symbols from the host side |
| eb_rx | input | 10 | Receive symbols returned by the external framer and buffer |
| framer_in | output | 10 | Symbols sent to the external framer |
| rx_out | output | 10 | Receive output toward the host side |
| tx_out | output | 10 | Transmit output toward the line |
| bist_busy | output | 1 | Self-test running |
| bist_done | output | 1 | One-cycle self-test completion pulse |

## Verification
All three symbol outputs are combinational functions of the stored mode bits and the live inputs. A wrong or wrongly gated mode bit therefore shows on the data ports in the first cycle after the write that set it. A write that should have been refused shows as soon as the state input moves back to a state where the bit would matter. A sequencer stuck in the wrong state shows as a busy window that is not 64 cycles long, a missing or doubled completion pulse, or a busy flag that rises without a fresh 0-then-1 write. The bench puts three distinct symbol values on `line_rx`, `tx_in` and `eb_rx`, so every mis-selection yields a value that can be told apart.

// File: rtl/lbk_pkg.sv
package lbk_pkg;

  localparam logic [1:0] MGMT_OFF   = 2'd0;
  localparam logic [1:0] MGMT_MAINT = 2'd1;

  // mode register image; bypass sits in bit 0
  typedef struct packed {
    logic bist_run;
    logic late_loop;
    logic early_loop;
    logic rem_loop;
    logic bypass;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  typedef enum logic [1:0] {
    RX_FROM_PATH = 2'd0,
    RX_FROM_TX   = 2'd1,
    RX_FROM_IDLE = 2'd2
  } rx_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bist_st_e;

endpackage

// File: rtl/lbk_mode_reg.sv
module lbk_mode_reg
  import lbk_pkg::*;
#(
  parameter int          ADDR_W   = 2,
  parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [MODE_W-1:0] wr_data,
  input  logic [1:0]        mgmt_state,
  output mode_t             mode
);

  mode_t mode_q, mode_d, wr_img;
  logic  hit, loop_wr_ok;

  always_comb begin
    wr_img     = mode_t'(wr_data);
    hit        = wr_en && (wr_addr == REG_ADDR);
    loop_wr_ok = (mgmt_state == MGMT_OFF) || (mgmt_state == MGMT_MAINT);
    mode_d     = mode_q;
    if (hit) begin
      mode_d.bypass   = wr_img.bypass;
      mode_d.rem_loop = wr_img.rem_loop;
      mode_d.bist_run = wr_img.bist_run;
      if (loop_wr_ok) begin
        mode_d.early_loop = wr_img.early_loop;
        mode_d.late_loop  = wr_img.late_loop;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mode_q <= '0;
    else if (hit) mode_q <= mode_d;
  end

  assign mode = mode_q;

  AST_LOOP_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mgmt_state[1]) |=> ($stable(mode_q.early_loop) && $stable(mode_q.late_loop))); // R5

  AST_ADDR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr != REG_ADDR) |=> $stable(mode_q)); // R13

endmodule

// File: rtl/lbk_selftest.sv
module lbk_selftest
  import lbk_pkg::*;
#(
  parameter int RUN_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic busy,
  output logic done
);

  localparam int CNT_W = (RUN_CYCLES > 1) ? $clog2(RUN_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_CYCLES - 1);

  bist_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    done_d = 1'b0;
    unique case (st_q)
      ST_IDLE: if (run) begin
        st_d  = ST_RUN;
        cnt_d = '0;
      end
      ST_RUN: begin
        if (!run) begin
          st_d = ST_IDLE;
        end else if (cnt_q == LAST) begin
          st_d   = ST_DONE;
          done_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DONE: if (!run) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (st_q == ST_RUN) || ((st_q == ST_IDLE) && run);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (st_q == ST_RUN);
  assign done = done_q;

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run) |=> (!busy && !done)); // R10

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DONE && run) |=> !busy); // R11

endmodule

// File: rtl/lbk_datapath.sv
module lbk_datapath
  import lbk_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  mode_t             mode,
  input  logic [1:0]        mgmt_state,
  input  logic              cfg_override,
  input  logic              scrub_req,
  input  logic              cipher_lpbk,
  input  logic              bist_busy,
  input  logic [DATA_W-1:0] line_rx,
  input  logic [DATA_W-1:0] tx_in,
  input  logic [DATA_W-1:0] eb_rx,
  output logic [DATA_W-1:0] framer_in,
  output logic [DATA_W-1:0] rx_out,
  output logic [DATA_W-1:0] tx_out
);

  localparam logic [DATA_W-1:0] IDLE_FILL = {DATA_W{1'b1}};

  logic              apply_en, byp_eff, rem_eff, early_eff;
  logic [DATA_W-1:0] recv_path;
  rx_src_e           rx_sel;

  always_comb begin
    apply_en  = (mgmt_state == MGMT_MAINT) || cfg_override;
    byp_eff   = mode.bypass && apply_en;
    early_eff = mode.early_loop || bist_busy;
    rem_eff   = mode.rem_loop && apply_en && !mode.early_loop
                && !mode.late_loop && !cipher_lpbk;
  end

  always_comb begin
    recv_path = mode.late_loop ? tx_in : eb_rx;
    framer_in = early_eff ? tx_in : line_rx;
    tx_out    = rem_eff ? recv_path : tx_in;
  end

  always_comb begin
    if (byp_eff) rx_sel = scrub_req ? RX_FROM_IDLE : RX_FROM_TX;
    else         rx_sel = RX_FROM_PATH;
    unique case (rx_sel)
      RX_FROM_TX:   rx_out = tx_in;
      RX_FROM_IDLE: rx_out = IDLE_FILL;
      default:      rx_out = recv_path;
    endcase
  end

endmodule

// File: rtl/lbk_path_ctrl.sv
module lbk_path_ctrl
  import lbk_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int ADDR_W      = 2,
  parameter int BIST_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [4:0]        wr_data,
  input  logic [1:0]        mgmt_state,
  input  logic              cfg_override,
  input  logic              scrub_req,
  input  logic              cipher_lpbk,
  input  logic [DATA_W-1:0] line_rx,
  input  logic [DATA_W-1:0] tx_in,
  input  logic [DATA_W-1:0] eb_rx,
  output logic [DATA_W-1:0] framer_in,
  output logic [DATA_W-1:0] rx_out,
  output logic [DATA_W-1:0] tx_out,
  output logic              bist_busy,
  output logic              bist_done
);

  mode_t mode;

  lbk_mode_reg #(.ADDR_W(ADDR_W), .REG_ADDR('0)) u_reg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mgmt_state (mgmt_state),
    .mode       (mode)
  );

  lbk_selftest #(.RUN_CYCLES(BIST_CYCLES)) u_bist (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode.bist_run),
    .busy  (bist_busy),
    .done  (bist_done)
  );

  lbk_datapath #(.DATA_W(DATA_W)) u_path (
    .mode         (mode),
    .mgmt_state   (mgmt_state),
    .cfg_override (cfg_override),
    .scrub_req    (scrub_req),
    .cipher_lpbk  (cipher_lpbk),
    .bist_busy    (bist_busy),
    .line_rx      (line_rx),
    .tx_in        (tx_in),
    .eb_rx        (eb_rx),
    .framer_in    (framer_in),
    .rx_out       (rx_out),
    .tx_out       (tx_out)
  );

  AST_IDLE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (mgmt_state == MGMT_MAINT && mode.bypass && scrub_req) |-> (&rx_out)); // R2

  AST_REMOTE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode.early_loop || mode.late_loop || cipher_lpbk) |-> (tx_out == tx_in)); // R8

  AST_BIST_FORCES_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    bist_busy |-> (framer_in == tx_in)); // R12

  AST_BIST_CLEAN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bist_busy) |-> $past(mode.bist_run)); // R9

endmodule

// File: tb/sim_lbk_path_ctrl.sv
module sim_lbk_path_ctrl;

  localparam logic [9:0] V_LINE = 10'h155;
  localparam logic [9:0] V_TX   = 10'h2A3;
  localparam logic [9:0] V_EB   = 10'h0C7;
  localparam logic [9:0] V_IDLE = 10'h3FF;
  localparam int NVEC = 16;

  // {mode[4:0], state[1:0], ovr, scrub, cipher, rx_src[1:0], tx_src, fr_src}
  // rx_src: 0 eb_rx, 1 tx_in, 2 idle; tx_src: 0 tx_in, 1 eb_rx; fr_src: 0 line, 1 tx
  localparam logic [13:0] VEC [NVEC] = '{
    {5'b00000, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R7 plain path
    {5'b00001, 2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},  // R2
    {5'b00001, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},  // R3
    {5'b00001, 2'd2, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 no effect
    {5'b00001, 2'd3, 1'b1, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},  // R4 override
    {5'b00001, 2'd0, 1'b0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 OFF not enough
    {5'b00010, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},  // R8
    {5'b00010, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0},  // R4 remote gated
    {5'b00010, 2'd2, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 1'b0},  // R4 remote override
    {5'b00110, 2'd1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},  // R8 early blocks, R6
    {5'b01010, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},  // R8 late blocks, R7
    {5'b00010, 2'd1, 1'b0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0},  // R8 cipher blocks
    {5'b01000, 2'd2, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0},  // R7
    {5'b01001, 2'd1, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 1'b0},  // R2 over late loop
    {5'b00100, 2'd3, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1},  // R6
    {5'b01001, 2'd1, 1'b0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0}   // R3
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [4:0] wr_data;
  logic [1:0] mgmt_state;
  logic       cfg_override, scrub_req, cipher_lpbk;
  logic [9:0] line_rx, tx_in, eb_rx;
  logic [9:0] framer_in, rx_out, tx_out;
  logic       bist_busy, bist_done;

  int n_chk = 0;
  int n_bad = 0;
  bit ended = 1'b0;

  always #4 clk = ~clk;

  lbk_path_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mgmt_state(mgmt_state), .cfg_override(cfg_override), .scrub_req(scrub_req),
    .cipher_lpbk(cipher_lpbk), .line_rx(line_rx), .tx_in(tx_in), .eb_rx(eb_rx),
    .framer_in(framer_in), .rx_out(rx_out), .tx_out(tx_out),
    .bist_busy(bist_busy), .bist_done(bist_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [4:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  function automatic logic [9:0] rx_val(input logic [1:0] s);
    case (s)
      2'd1:    return V_TX;
      2'd2:    return V_IDLE;
      default: return V_EB;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int busy_n, done_n, fr_bad, seen;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mgmt_state = 2'd0; cfg_override = 1'b0; scrub_req = 1'b0; cipher_lpbk = 1'b0;
    line_rx = V_LINE; tx_in = V_TX; eb_rx = V_EB;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rx_out", rx_out, V_EB);
    check("R1 tx_out", tx_out, V_TX);
    check("R1 framer_in", framer_in, V_LINE);
    check("R1 busy/done", {bist_busy, bist_done}, 2'b00);

    // table walk over multiplexer selections
    for (int i = 0; i < NVEC; i++) begin
      logic [13:0] v;
      v = VEC[i];
      mgmt_state = 2'd1; cfg_override = 1'b0;
      wr(2'd0, v[13:9]);
      mgmt_state = v[8:7]; cfg_override = v[6]; scrub_req = v[5]; cipher_lpbk = v[4];
      #1;
      check($sformatf("R2-R8 vector %0d", i),
            {rx_out, tx_out, framer_in},
            {rx_val(v[3:2]), (v[1] ? V_EB : V_TX), (v[0] ? V_TX : V_LINE)});
    end
    cfg_override = 1'b0; scrub_req = 1'b0; cipher_lpbk = 1'b0;

    // R5: loop bits locked outside OFF/MAINT
    mgmt_state = 2'd1; wr(2'd0, 5'b00000);
    mgmt_state = 2'd2; wr(2'd0, 5'b00100);
    #1 check("R5 early write refused in state 2", framer_in, V_LINE);
    mgmt_state = 2'd0; wr(2'd0, 5'b01000);
    #1 check("R5 late write taken in OFF", rx_out, V_TX);
    mgmt_state = 2'd3; wr(2'd0, 5'b00000);
    #1 check("R5 late clear refused in state 3", rx_out, V_TX);

    // R4: bypass stored in state 2, applied once in MAINT
    mgmt_state = 2'd1; wr(2'd0, 5'b00000);
    mgmt_state = 2'd2; scrub_req = 1'b1; wr(2'd0, 5'b00001);
    #1 check("R4 bypass inert in state 2", rx_out, V_EB);
    mgmt_state = 2'd1;
    #1 check("R4 bypass acts in MAINT", rx_out, V_IDLE);

    // R13: other addresses ignored
    wr(2'd0, 5'b00000); scrub_req = 1'b0;
    wr(2'd1, 5'b00001);
    #1 check("R13 write to address 1 ignored", rx_out, V_EB);
    wr(2'd3, 5'b00100);
    #1 check("R13 write to address 3 ignored", framer_in, V_LINE);

    // R9/R12: full self-test run
    wr(2'd0, 5'b10000);
    busy_n = 0; done_n = 0; fr_bad = 0;
    for (int c = 0; c < 100; c++) begin
      @(negedge clk);
      if (bist_busy) begin
        busy_n++;
        if (framer_in !== V_TX) fr_bad++;
      end
      if (bist_done) done_n++;
    end
    check("R9 busy cycles", busy_n, 64);
    check("R9 done pulses", done_n, 1);
    check("R12 framer_in during busy mismatches", fr_bad, 0);
    check("R12 framer_in after run", framer_in, V_LINE);

    // R11: held run does not restart
    seen = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (bist_busy || bist_done) seen++;
    end
    check("R11 no restart while held", seen, 0);
    wr(2'd0, 5'b00000);
    wr(2'd0, 5'b10000);
    @(negedge clk);
    check("R11 restart after 0 then 1", bist_busy, 1'b1);

    // R10: abort
    repeat (10) @(negedge clk);
    wr(2'd0, 5'b00000);
    check("R10 busy still high before abort takes hold", bist_busy, 1'b1);
    @(negedge clk);
    check("R10 busy dropped after abort", bist_busy, 1'b0);
    seen = 0;
    for (int c = 0; c < 80; c++) begin
      @(negedge clk);
      if (bist_done || bist_busy) seen++;
    end
    check("R10 no completion after abort", seen, 0);

    finish_run();
  end

endmodule